// File: doc/BRIEF.md
# Double-Buffered Serial/Byte Converter Input Port

This block is the digital front end of a 16-bit digital-to-analog converter. A code is assembled in a staging word, either by shifting it in one bit at a time or by writing its two bytes, and is then copied into the output word that sets the converter. Because the two words are separate, many converters can be loaded one after another and then updated together from one shared load line.

In serial mode two lines of the byte bus take new roles: bit 0 carries the serial data, and bit 7 selects the shift direction. The low-byte enable becomes the serial clock, and one bit is shifted in for each rising edge seen on it. A serial output presents the bit that leaves the staging word next, so the next device in a chain can take it as its serial input. An asynchronous clear puts the converter at zero volts: it loads the output word with all zeros for a unipolar range, or with mid-scale for a bipolar offset-binary range, and empties the staging word.

All inputs other than the clear are sampled on the rising edge of `clk`.

Top module: `dac_front_end`

## Requirements
- R1: While `clr` is high, `dac_code` is 16'h0000 when `clr_bipolar` is 0 and 16'h8000 when it is 1, and takes that value without waiting for a clock edge. The staging word is also set to zero.
- R2: `clr` overrides `load`, byte writes and serial shifts that are active in the same cycles.
- R3: On each clock edge where `load` is 1, `dac_code` takes the staging word as it stood before that edge. While `load` is 0, `dac_code` does not change.
- R4: In byte mode (`ser_mode` = 0) with `sel` = 1, `hi_en` = 1 writes `data` into staging bits 15:8 and `lo_en` = 1 writes `data` into bits 7:0. The same word results whichever byte is written first.
- R5: In serial mode (`ser_mode` = 1) with `sel` = 1, a clock edge where `lo_en` is 1 and was 0 at the previous edge shifts `data[0]` into the staging word. When `data[7]` = 1 (MSB first) the bit enters bit 0 and the word moves up. When `data[7]` = 0 (LSB first) the bit enters bit 15 and the word moves down.
- R6: `ser_out` is staging bit 0 when `ser_mode` = 1 and `data[7]` = 0. In every other case it is staging bit 15.
- R7: While `sel` = 0, writes and shifts have no effect on the staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| clr | input | 1 | Asynchronous clear, active high |
| clr_bipolar | input | 1 | 1 selects a bipolar range, so clear loads mid-scale |
| sel | input | 1 | Device select, active high |
| ser_mode | input | 1 | 1 for serial input, 0 for byte input |
| hi_en | input | 1 | High-byte write enable |
| lo_en | input | 1 | Low-byte write enable; serial clock in serial mode |
| data | input | 8 | Byte bus; bit 0 is serial data and bit 7 is the direction in serial mode |
| load | input | 1 | Level load strobe into the output word |
| dac_code | output | 16 | Output word driving the converter |
| ser_out | output | 1 | Next outgoing staging bit, for chaining |

## Verification
The bench writes the two bytes in both orders and checks that the loaded words match. A design that decoded the enables the wrong way round would swap or lose a byte. Shifts in both directions catch a reversed shift or a wrong insertion end. The chained output is followed bit by bit while a new word pushes the old one out, which exposes a tap on the wrong end. Clears are applied mid-cycle and together with load and writes, where a synchronous or low-priority clear would leave a stale code. A write with `sel` low is checked at the ports, to catch an ignored select.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned BW = 8;

  function automatic logic [DW-1:0] clear_code(input logic bipolar);
    clear_code = '0;
    if (bipolar) clear_code[DW-1] = 1'b1;
  endfunction

  function automatic logic [DW-1:0] shift_word(input logic [DW-1:0] w,
                                                input logic bit_in,
                                                input logic msb_first);
    if (msb_first) shift_word = {w[DW-2:0], bit_in};
    else           shift_word = {bit_in, w[DW-1:1]};
  endfunction

  function automatic logic tap(input logic [DW-1:0] w, input logic msb_first);
    tap = msb_first ? w[DW-1] : w[0];
  endfunction
endpackage

// File: rtl/dacfe_strobe.sv
module dacfe_strobe (
  input  logic clk,
  input  logic clr,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/dacfe_stage.sv
module dacfe_stage
  import dacfe_pkg::*;
#(
  parameter int unsigned WORD_W = DW,
  parameter int unsigned BYTE_W = BW
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              sel,
  input  logic              ser_mode,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic              shift_evt,
  input  logic              sin,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned HALVES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] nxt;
  logic [HALVES-1:0] byte_we;

  assign byte_we[0] = sel & ~ser_mode & lo_en;
  assign byte_we[HALVES-1] = sel & ~ser_mode & hi_en;

  always_comb begin
    nxt = word;
    if (shift_evt) nxt = shift_word(word, sin, msb_first);
    for (int h = 0; h < HALVES; h++)
      if (byte_we[h]) nxt[h*BYTE_W +: BYTE_W] = data;
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) word <= '0;
    else     word <= nxt;
  end
endmodule

// File: rtl/dacfe_out_reg.sv
module dacfe_out_reg
  import dacfe_pkg::*;
#(
  parameter int unsigned WORD_W = DW
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              clr_bipolar,
  input  logic              load,
  input  logic [WORD_W-1:0] stage,
  output logic [WORD_W-1:0] code
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)       code <= clear_code(clr_bipolar);
    else if (load) code <= stage;
  end
endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
  import dacfe_pkg::*;
#(
  parameter int unsigned WORD_W  = DW,
  parameter int unsigned BYTE_W  = BW,
  parameter int unsigned SIN_BIT = 0,
  parameter int unsigned DIR_BIT = BW - 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              clr_bipolar,
  input  logic              sel,
  input  logic              ser_mode,
  input  logic              hi_en,
  input  logic              lo_en,
  input  logic [BYTE_W-1:0] data,
  input  logic              load,
  output logic [WORD_W-1:0] dac_code,
  output logic              ser_out
);
  logic              lo_rise;
  logic              shift_evt;
  logic              msb_first;
  logic              sin;
  logic [WORD_W-1:0] in_word;

  assign sin       = data[SIN_BIT];
  assign msb_first = ~ser_mode | data[DIR_BIT];
  assign shift_evt = sel & ser_mode & lo_rise;
  assign ser_out   = tap(in_word, msb_first);

  dacfe_strobe u_strobe (
    .clk(clk), .clr(clr), .strobe(lo_en), .rise(lo_rise)
  );

  dacfe_stage #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .clr(clr), .sel(sel), .ser_mode(ser_mode),
    .hi_en(hi_en), .lo_en(lo_en), .shift_evt(shift_evt),
    .sin(sin), .msb_first(msb_first), .data(data), .word(in_word)
  );

  dacfe_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .clr(clr), .clr_bipolar(clr_bipolar), .load(load),
    .stage(in_word), .code(dac_code)
  );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              clr,
  input logic              clr_bipolar,
  input logic              sel,
  input logic              load,
  input logic              shift_evt,
  input logic              msb_first,
  input logic              sin,
  input logic [WORD_W-1:0] in_word,
  input logic [WORD_W-1:0] dac_code
);
  AST_CLEAR_CODE: assert property (@(posedge clk)
    clr |-> dac_code == (clr_bipolar ? {1'b1, {(WORD_W-1){1'b0}}} : '0)); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk)
    (clr && load) |-> in_word == '0); // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (clr)
    !load |=> $stable(dac_code)); // R3
  AST_LOAD_TAKES_STAGE: assert property (@(posedge clk) disable iff (clr)
    load |=> dac_code == $past(in_word)); // R3
  AST_SHIFT_MSB_END: assert property (@(posedge clk) disable iff (clr)
    (shift_evt && msb_first) |=> in_word[0] == $past(sin)); // R5
  AST_SHIFT_LSB_END: assert property (@(posedge clk) disable iff (clr)
    (shift_evt && !msb_first) |=> in_word[WORD_W-1] == $past(sin)); // R5
  AST_IDLE_UNSELECTED: assert property (@(posedge clk) disable iff (clr)
    !sel |=> $stable(in_word)); // R7
endmodule

bind dac_front_end dacfe_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .clr(clr), .clr_bipolar(clr_bipolar), .sel(sel), .load(load),
  .shift_evt(shift_evt), .msb_first(msb_first), .sin(sin),
  .in_word(in_word), .dac_code(dac_code)
);

// File: tb/tb_dac_front_end.sv
module tb_dac_front_end;
  logic        clk = 0;
  logic        clr = 1, clr_bipolar = 0, sel = 0, ser_mode = 0;
  logic        hi_en = 0, lo_en = 0, load = 0;
  logic [7:0]  data = 0;
  logic [15:0] dac_code;
  logic        ser_out;

  int checks = 0, errors = 0;
  logic [15:0] bm = 0;            // bench model of the staging word
  logic [15:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #4 clk = ~clk;

  dac_front_end dut (
    .clk(clk), .clr(clr), .clr_bipolar(clr_bipolar), .sel(sel),
    .ser_mode(ser_mode), .hi_en(hi_en), .lo_en(lo_en), .data(data),
    .load(load), .dac_code(dac_code), .ser_out(ser_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected codes as the driver announces completed loads
  initial forever begin
    @(mon_ev);
    if (exp_q.size() > 0) check(tag_q.pop_front(), dac_code, exp_q.pop_front());
  end

  task automatic do_load(input string req);
    @(negedge clk) load = 1;
    @(negedge clk) load = 0;
    exp_q.push_back(bm); tag_q.push_back(req);
    -> mon_ev;
    #1;
  endtask

  task automatic wr_byte(input logic hi, input logic [7:0] v, input logic s);
    @(negedge clk) begin sel = s; ser_mode = 0; hi_en = hi; lo_en = !hi; data = v; end
    @(negedge clk) begin hi_en = 0; lo_en = 0; sel = 0; end
    if (s) begin if (hi) bm[15:8] = v; else bm[7:0] = v; end
  endtask

  task automatic shift_word_in(input logic [15:0] w, input logic msb, input logic chk_out);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = msb ? w[15-i] : w[i];
      @(negedge clk) begin sel = 1; ser_mode = 1; data = {msb, 6'b0, b}; end
      #1;
      if (chk_out) check("R6 ser_out", {15'b0, ser_out}, {15'b0, msb ? bm[15] : bm[0]});
      lo_en = 1;
      @(negedge clk) lo_en = 0;
      bm = msb ? {bm[14:0], b} : {b, bm[15:1]};
    end
    @(negedge clk) begin sel = 0; ser_mode = 0; data = 0; end
  endtask

  task automatic do_clear(input logic bip);
    @(negedge clk) clr_bipolar = bip;
    #1 clr = 1;
    #1 check("R1 async clear", dac_code, bip ? 16'h8000 : 16'h0000);
    @(negedge clk) clr = 0;
    bm = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset unipolar", dac_code, 16'h0000);
    check("R6 reset ser_out", {15'b0, ser_out}, 16'h0000);
    clr = 0;
    // R4 bytes high then low
    wr_byte(1, 8'hA5, 1); wr_byte(0, 8'h3C, 1);
    do_load("R4 hi-then-lo");
    check("R4 word", dac_code, 16'hA53C);
    // R4 low then high, same word
    wr_byte(0, 8'h3C, 1); wr_byte(1, 8'hA5, 1);
    do_load("R4 lo-then-hi");
    // R3 hold: change staging with load low
    wr_byte(1, 8'h11, 1);
    repeat (3) @(negedge clk);
    check("R3 hold", dac_code, 16'hA53C);
    do_load("R3 load");
    // R6 byte mode tap is bit 15
    #1 check("R6 byte tap", {15'b0, ser_out}, {15'b0, bm[15]});
    // R7 unselected write ignored
    wr_byte(1, 8'hFF, 0); wr_byte(0, 8'hEE, 0);
    do_load("R7 sel low");
    // R5 serial MSB first, R6 daisy output
    shift_word_in(16'hC35A, 1, 1);
    do_load("R5 msb first");
    check("R5 msb word", dac_code, 16'hC35A);
    // R5 LSB first, R6 tap on bit 0
    shift_word_in(16'h1234, 0, 1);
    do_load("R5 lsb first");
    check("R5 lsb word", dac_code, 16'h1234);
    // R1 bipolar clear
    do_clear(1);
    check("R1 bipolar hold", dac_code, 16'h8000);
    do_load("R1 staging cleared");
    // R2 clear with load and write active
    wr_byte(0, 8'h77, 1);
    @(negedge clk) begin clr_bipolar = 1; load = 1; sel = 1; hi_en = 1; data = 8'h99; clr = 1; end
    @(negedge clk) check("R2 clear over load", dac_code, 16'h8000);
    begin hi_en = 0; sel = 0; load = 0; clr = 0; end
    bm = 0;
    do_load("R2 staging cleared");
    do_clear(0);
    check("R1 unipolar", dac_code, 16'h0000);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule